// File: doc/BRIEF.md
# UART Receive/Transmit Hardware Flow Control

This block decides, cycle by cycle, whether the far end may keep sending to a UART and whether the local transmitter may start its next character. On the receive side it drives the request-to-send pin (active low) from the receive FIFO fill level. Two thresholds give it hysteresis: a halt level where the pin is deasserted, and a lower restore level where it is asserted again. Both thresholds come from one 8-bit trigger byte. Each nibble of that byte is multiplied by FIFO_DEPTH/16, which is 4 for the default 64-entry FIFO. When automatic control is off, the pin copies a manual value supplied by the modem-control logic.

On the transmit side, the clear-to-send pin (active low) passes through a two-flop synchronizer. When automatic control is on, a high level withdraws the transmitter's permission to start a character. The block samples that permission only while the transmitter is idle, so a character already being shifted out is always completed. The block also produces single-cycle pulses when either flow-control line goes from low to high, and the interrupt logic reports these as its lowest-priority source.

The two enables and the trigger byte are held in a small configuration register. It loads only when the write strobe arrives while the enhanced-function enable is set.

Top module: `uart_flowctl`

## Requirements
- R1: After reset, rts_n is 0, tx_allow is 1, both event outputs are 0, both automatic modes are off and the trigger byte is 0.
- R2: cfg_rts_en, cfg_cts_en and cfg_tcr are captured on a rising edge only when cfg_we and enh_en are both 1 on that edge. A write with enh_en at 0 leaves rts_n and tx_allow behaving as before.
- R3: While automatic RTS control is off, rts_n equals the rts_manual_n value from the previous cycle.
- R4: While automatic RTS control is on, rx_count >= 4*cfg_tcr[3:0] (the halt level) sets rts_n to 1 on the next cycle.
- R5: While automatic RTS control is on and rx_count is below the halt level, rx_count <= 4*cfg_tcr[7:4] (the restore level) sets rts_n to 0 on the next cycle.
- R6: While automatic RTS control is on and rx_count is strictly between the restore and halt levels, rts_n keeps its previous value.
- R7: When a count satisfies both the halt and the restore comparison, the halt comparison wins.
- R8: With automatic CTS control on and tx_idle at 1, tx_allow becomes the inverse of cts_pin_n on the third rising edge after the pin changes.
- R9: While tx_idle is 0, tx_allow keeps its value. The new permission takes effect on the edge after tx_idle returns to 1.
- R10: While automatic CTS control is off, tx_allow is 1 whatever cts_pin_n does.
- R11: rts_rise_evt is high for exactly the one cycle in which rts_n first reads 1 after reading 0 under automatic control. A rise that comes from manual control gives no pulse.
- R12: With automatic CTS control on, a low-to-high change of cts_pin_n drives cts_rise_evt high for exactly one cycle, starting at the second rising edge after the change. When CTS control is off, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enh_en | input | 1 | Enhanced-function enable; gates configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rts_en | input | 1 | Automatic RTS control enable (write data) |
| cfg_cts_en | input | 1 | Automatic CTS control enable (write data) |
| cfg_tcr | input | 8 | Trigger byte: [3:0] halt nibble, [7:4] restore nibble (write data) |
| rts_manual_n | input | 1 | Manual RTS pin level used when automatic control is off |
| rx_count | input | CNT_W | Receive FIFO entry count |
| cts_pin_n | input | 1 | Asynchronous clear-to-send pin, high means stop |
| tx_idle | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Request-to-send pin level, high means stop |
| tx_allow | output | 1 | Transmitter may start a new character |
| rts_rise_evt | output | 1 | One-cycle pulse on an automatic RTS low-to-high change |
| cts_rise_evt | output | 1 | One-cycle pulse on a synchronized CTS low-to-high change |

## Verification
The FIFO count is stepped across the hysteresis band in both directions. It is set onto each threshold exactly, held inside the band after approaching from above and from below, and placed on a level where the two thresholds meet. Together these separate an off-by-one compare, a missing hold and a wrong priority. The CTS pin is toggled with the transmitter idle, with it busy, and with the mode off. This shows the synchronizer latency, the character-boundary gating and the enable each on their own. Configuration writes are tried with and without the enhanced enable, so that a write that was ignored shows up as unchanged pin behaviour.

// File: rtl/fc_pkg.sv
// Package fc_pkg: shared configuration type and threshold scaling for the
// UART flow-control block. Assumes a FIFO depth that is a multiple of 16.
package fc_pkg;

    typedef struct packed {
        logic       rts_en;
        logic       cts_en;
        logic [7:0] tcr;
    } fc_cfg_t;

    // Scale a 4-bit trigger nibble into a FIFO entry count.
    function automatic logic [15:0] fc_scale(input logic [3:0] nib, input int step);
        return 16'(nib) * 16'(step);
    endfunction

endpackage

// File: rtl/fc_cfg_reg.sv
// fc_cfg_reg: holds the flow-control enables and trigger byte. A write lands
// only when the enhanced-function enable is set; otherwise the write is dropped.
module fc_cfg_reg
    import fc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enh_en,
    input  logic    we,
    input  fc_cfg_t wdata,
    output fc_cfg_t cfg
);

    // Capture configuration on a gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && enh_en) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/fc_sync.sv
// fc_sync: multi-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level, not a pulse.
module fc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/fc_rts_ctrl.sv
// fc_rts_ctrl: drives the RTS pin from the FIFO level with halt/restore
// hysteresis, or from a manual level when automatic mode is off.
// Halt takes precedence when both comparisons hold.
module fc_rts_ctrl #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             manual_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] halt_lvl,
    input  logic [CNT_W-1:0] rest_lvl,
    output logic             rts_n,
    output logic             rise_evt
);

    logic rts_nxt;

    // Next pin level: manual copy, halt, restore, or hold.
    always_comb begin
        if (!auto_en) begin
            rts_nxt = manual_n;
        end else if (count >= halt_lvl) begin
            rts_nxt = 1'b1;
        end else if (count <= rest_lvl) begin
            rts_nxt = 1'b0;
        end else begin
            rts_nxt = rts_n;
        end
    end

    // Register the pin level and flag an automatic low-to-high change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_n    <= 1'b0;
            rise_evt <= 1'b0;
        end else begin
            rts_n    <= rts_nxt;
            rise_evt <= auto_en && rts_nxt && !rts_n;
        end
    end

endmodule

// File: rtl/fc_cts_gate.sv
// fc_cts_gate: turns the synchronized CTS level into a start-of-character
// permission. It updates only when the transmitter is idle, so a character in
// flight always finishes. It also flags a synchronized low-to-high change.
module fc_cts_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_s,
    input  logic tx_idle,
    output logic tx_allow,
    output logic rise_evt
);

    logic cts_prev;

    // Update permission at character boundaries; free-run when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_allow <= 1'b1;
        end else if (!auto_en) begin
            tx_allow <= 1'b1;
        end else if (tx_idle) begin
            tx_allow <= !cts_s;
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_prev <= 1'b0;
        end else begin
            cts_prev <= cts_s;
        end
    end

    assign rise_evt = auto_en && cts_s && !cts_prev;

endmodule

// File: rtl/uart_flowctl.sv
// uart_flowctl: automatic RTS/CTS flow control for a UART with a receive
// FIFO. Assumes rx_count is synchronous to clk and never exceeds FIFO_DEPTH.
module uart_flowctl
    import fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enh_en,
    input  logic             cfg_we,
    input  logic             cfg_rts_en,
    input  logic             cfg_cts_en,
    input  logic [7:0]       cfg_tcr,
    input  logic             rts_manual_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             cts_pin_n,
    input  logic             tx_idle,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             rts_rise_evt,
    output logic             cts_rise_evt
);

    localparam int STEP = FIFO_DEPTH / 16;

    fc_cfg_t          cfg_wr;
    fc_cfg_t          cfg_q;
    logic             rts_en_q;
    logic             cts_en_q;
    logic [7:0]       tcr_q;
    logic [15:0]      halt_w;
    logic [15:0]      rest_w;
    logic [CNT_W-1:0] halt_lvl;
    logic [CNT_W-1:0] rest_lvl;
    logic             cts_s;

    // Pack the write data into the configuration type.
    always_comb begin
        cfg_wr.rts_en = cfg_rts_en;
        cfg_wr.cts_en = cfg_cts_en;
        cfg_wr.tcr    = cfg_tcr;
    end

    fc_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enh_en (enh_en),
        .we     (cfg_we),
        .wdata  (cfg_wr),
        .cfg    (cfg_q)
    );

    assign rts_en_q = cfg_q.rts_en;
    assign cts_en_q = cfg_q.cts_en;
    assign tcr_q    = cfg_q.tcr;

    // Derive entry-count thresholds from the trigger nibbles.
    always_comb begin
        halt_w   = fc_scale(tcr_q[3:0], STEP);
        rest_w   = fc_scale(tcr_q[7:4], STEP);
        halt_lvl = halt_w[CNT_W-1:0];
        rest_lvl = rest_w[CNT_W-1:0];
    end

    fc_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (rts_en_q),
        .manual_n (rts_manual_n),
        .count    (rx_count),
        .halt_lvl (halt_lvl),
        .rest_lvl (rest_lvl),
        .rts_n    (rts_n),
        .rise_evt (rts_rise_evt)
    );

    fc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_pin_n),
        .q_sync  (cts_s)
    );

    fc_cts_gate u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (cts_en_q),
        .cts_s    (cts_s),
        .tx_idle  (tx_idle),
        .tx_allow (tx_allow),
        .rise_evt (cts_rise_evt)
    );

endmodule

// File: rtl/uart_flowctl_chk.sv
// uart_flowctl_chk: temporal properties of the flow-control block, bound
// into every uart_flowctl instance.
module uart_flowctl_chk #(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enh_en,
    input logic             cfg_we,
    input logic             rts_manual_n,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_idle,
    input logic             rts_n,
    input logic             tx_allow,
    input logic             rts_rise_evt,
    input logic             cts_rise_evt,
    input logic             rts_en_q,
    input logic             cts_en_q,
    input logic [7:0]       tcr_q
);

    localparam int STEP = FIFO_DEPTH / 16;

    logic [CNT_W+4:0] halt_c;
    logic [CNT_W+4:0] rest_c;
    logic [CNT_W+4:0] cnt_c;

    // Widened thresholds and count for comparison.
    always_comb begin
        halt_c = (CNT_W+5)'(tcr_q[3:0]) * (CNT_W+5)'(STEP);
        rest_c = (CNT_W+5)'(tcr_q[7:4]) * (CNT_W+5)'(STEP);
        cnt_c  = (CNT_W+5)'(rx_count);
    end

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && enh_en) |=> ($stable(tcr_q) && $stable(rts_en_q) && $stable(cts_en_q)));

    a_r3_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_en_q |=> (rts_n == $past(rts_manual_n)));

    a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_en_q && cnt_c >= halt_c) |=> rts_n);

    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_en_q && cnt_c < halt_c && cnt_c <= rest_c) |=> !rts_n);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_en_q && cnt_c < halt_c && cnt_c > rest_c) |=> $stable(rts_n));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && cts_en_q) |=> $stable(tx_allow));

    a_r10_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_en_q |=> tx_allow);

    a_r11_rts_evt_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rts_rise_evt |-> (rts_n && !$past(rts_n)));

    a_r11_rts_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rts_rise_evt |=> !rts_rise_evt);

    a_r12_cts_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cts_rise_evt |=> !cts_rise_evt);

endmodule

bind uart_flowctl uart_flowctl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enh_en       (enh_en),
    .cfg_we       (cfg_we),
    .rts_manual_n (rts_manual_n),
    .rx_count     (rx_count),
    .tx_idle      (tx_idle),
    .rts_n        (rts_n),
    .tx_allow     (tx_allow),
    .rts_rise_evt (rts_rise_evt),
    .cts_rise_evt (cts_rise_evt),
    .rts_en_q     (rts_en_q),
    .cts_en_q     (cts_en_q),
    .tcr_q        (tcr_q)
);

// File: tb/uart_flowctl_tb.sv
// uart_flowctl_tb: scoreboard bench. The driver queues expected output
// values tagged with the cycle they apply to; a monitor compares them.
module uart_flowctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 7;
    localparam int WATCHDOG   = 5000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enh_en, cfg_we, cfg_rts_en, cfg_cts_en;
    logic [7:0]       cfg_tcr;
    logic             rts_manual_n;
    logic [CNT_W-1:0] rx_count;
    logic             cts_pin_n, tx_idle;
    logic             rts_n, tx_allow, rts_rise_evt, cts_rise_evt;

    typedef struct {
        int         cyc;
        logic [3:0] mask;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    cnt    = 0;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_flowctl u_dut (
        .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .cfg_we(cfg_we),
        .cfg_rts_en(cfg_rts_en), .cfg_cts_en(cfg_cts_en), .cfg_tcr(cfg_tcr),
        .rts_manual_n(rts_manual_n), .rx_count(rx_count), .cts_pin_n(cts_pin_n),
        .tx_idle(tx_idle), .rts_n(rts_n), .tx_allow(tx_allow),
        .rts_rise_evt(rts_rise_evt), .cts_rise_evt(cts_rise_evt)
    );

    always @(posedge clk) cnt <= cnt + 1;

    // Bit order of expectations: {rts_n, tx_allow, rts_rise_evt, cts_rise_evt}
    task automatic expect_in(input int n, input logic [3:0] m, input logic [3:0] e, input string r);
        item_t it;
        it.cyc = cnt + n; it.mask = m; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic en, input logic re, input logic ce, input logic [7:0] t);
        enh_en = en; cfg_we = 1'b1; cfg_rts_en = re; cfg_cts_en = ce; cfg_tcr = t;
    endtask

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cnt) begin
            item_t it;
            logic [3:0] act;
            it  = q.pop_front();
            act = {rts_n, tx_allow, rts_rise_evt, cts_rise_evt};
            checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: cycle %0d actual %b expected %b (mask %b)",
                         it.req, cnt, act, it.exp, it.mask);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enh_en = 1'b0; cfg_we = 1'b0; cfg_rts_en = 1'b0;
        cfg_cts_en = 1'b0; cfg_tcr = 8'h00; rts_manual_n = 1'b0;
        rx_count = '0; cts_pin_n = 1'b0; tx_idle = 1'b1;
        tick(3);
        rst_n = 1'b1;
        expect_in(1, 4'b1111, 4'b0100, "R1");
        tick(2);

        // R3 manual follow, no R11 pulse on a manual rise
        rts_manual_n = 1'b1;
        expect_in(1, 4'b1010, 4'b1000, "R3");
        expect_in(2, 4'b0010, 4'b0000, "R11");
        tick(2);
        rts_manual_n = 1'b0;
        expect_in(1, 4'b1000, 4'b0000, "R3");
        tick(2);

        // R2 write ignored without enhanced enable (halt 16, restore 4)
        rx_count = 7'd20;
        write_cfg(1'b0, 1'b1, 1'b0, 8'h14);
        expect_in(2, 4'b1000, 4'b0000, "R2");
        expect_in(3, 4'b1000, 4'b0000, "R2");
        tick(1); cfg_we = 1'b0;
        tick(3);

        // R2 write accepted; R4 halt and R11 pulse
        write_cfg(1'b1, 1'b1, 1'b0, 8'h14);
        expect_in(1, 4'b1000, 4'b0000, "R2");
        expect_in(2, 4'b1010, 4'b1010, "R4");
        expect_in(3, 4'b1010, 4'b1000, "R11");
        tick(1); cfg_we = 1'b0;
        tick(3);

        // R6 hold high inside the band, R5 restore on the exact level
        rx_count = 7'd10;
        expect_in(1, 4'b1000, 4'b1000, "R6");
        expect_in(2, 4'b1000, 4'b1000, "R6");
        tick(2);
        rx_count = 7'd4;
        expect_in(1, 4'b1000, 4'b0000, "R5");
        tick(1);
        rx_count = 7'd10;
        expect_in(1, 4'b1000, 4'b0000, "R6");
        tick(1);
        rx_count = 7'd15;
        expect_in(1, 4'b1000, 4'b0000, "R4");
        tick(1);
        rx_count = 7'd16;
        expect_in(1, 4'b1010, 4'b1010, "R4");
        tick(1);
        rx_count = 7'd5;
        expect_in(1, 4'b1010, 4'b1000, "R6");
        tick(1);
        rx_count = 7'd0;
        expect_in(2, 4'b1000, 4'b0000, "R5");
        tick(2);

        // R7 overlapping levels: halt 12, restore 20, count 12
        rx_count = 7'd12;
        write_cfg(1'b1, 1'b1, 1'b0, 8'h53);
        expect_in(1, 4'b1000, 4'b0000, "R6");
        expect_in(2, 4'b1000, 4'b1000, "R7");
        tick(1); cfg_we = 1'b0;
        tick(3);

        // R3 back to manual
        rts_manual_n = 1'b0;
        write_cfg(1'b1, 1'b0, 1'b1, 8'h53);
        expect_in(2, 4'b1010, 4'b0000, "R3");
        tick(1); cfg_we = 1'b0;
        tick(3);

        // R8 and R12 with the transmitter idle
        cts_pin_n = 1'b1;
        expect_in(1, 4'b0101, 4'b0100, "R8");
        expect_in(2, 4'b0101, 4'b0101, "R12");
        expect_in(3, 4'b0101, 4'b0000, "R8");
        tick(5);

        // R9 busy transmitter holds the permission
        tx_idle = 1'b0; cts_pin_n = 1'b0;
        expect_in(3, 4'b0100, 4'b0000, "R9");
        expect_in(5, 4'b0100, 4'b0000, "R9");
        tick(5);
        tx_idle = 1'b1;
        expect_in(1, 4'b0100, 4'b0100, "R9");
        tick(2);
        tx_idle = 1'b0; cts_pin_n = 1'b1;
        expect_in(2, 4'b0001, 4'b0001, "R12");
        expect_in(4, 4'b0100, 4'b0100, "R9");
        tick(4);
        tx_idle = 1'b1;
        expect_in(1, 4'b0100, 4'b0000, "R9");
        tick(2);

        // R10 CTS control off
        write_cfg(1'b1, 1'b0, 1'b0, 8'h53);
        expect_in(2, 4'b0100, 4'b0100, "R10");
        tick(1); cfg_we = 1'b0;
        tick(3);
        cts_pin_n = 1'b0;
        tick(3);
        cts_pin_n = 1'b1;
        expect_in(2, 4'b0101, 4'b0100, "R10");
        expect_in(3, 4'b0101, 4'b0100, "R12");
        expect_in(4, 4'b0101, 4'b0100, "R10");
        tick(6);

        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule